// File: doc/BRIEF.md
# Switching Cycle Timer with Sync Input and Short-Circuit Foldback

This block decides when each switching cycle of a buck converter begins. It produces a one-cycle strobe that turns the high-side switch on. It runs from a fast system clock. While no external timing source is present, it counts a fixed number of system-clock ticks per switching period. When a sync pin toggles, each falling edge on that pin starts a cycle instead. If the edges stop for one and a half nominal periods, the block goes back to its own counter.

A short-circuit flag from the feedback comparator cuts the switching rate to a third of normal. The block does this by letting only every third cycle event through, whether the events come from the internal counter or from the pin. The modulator's turn-off request is gated by a minimum on-time window that opens at each strobe. A request that arrives too early is held and released at the end of the window. A sync pin that stays low for the fallback interval raises a flag that selects pulse-skipping operation downstream.

The nominal period and the minimum on-time are parameters in system-clock ticks. The defaults are 16 ticks per period and 4 ticks of minimum on-time, so the fallback interval is 24 ticks.

Top module: `swfold_cycle_gen`

## Requirements
- R1: With no sync edges and the short flag low, `cycle_start` pulses for exactly one clock every PERIOD_TICKS clocks.
- R2: A falling edge on `sync_in` raises `cycle_start` on the third rising clock edge after the low level is first sampled. While edges keep arriving, the strobe spacing equals the edge spacing and no internal strobe is inserted.
- R3: While `short_flag` is high, only every third cycle event produces a strobe. The first event after the flag rises produces one, so strobe spacing becomes three times the event spacing, for internal and external events alike.
- R4: A turn-off request seen before the minimum on-time has elapsed is held. It produces an `off_gated` pulse exactly MIN_ON_TICKS clocks after the rising edge of `cycle_start`.
- R5: A turn-off request arriving after the window has closed produces `off_gated` one clock later.
- R6: `off_gated` pulses at most once per strobe, and never before the first strobe after reset.
- R7: If no sync falling edge arrives for PERIOD_TICKS + PERIOD_TICKS/2 clocks, internal timing resumes. The internal phase restarts at every cycle event, so with the defaults the first internal strobe comes 2*PERIOD_TICKS clocks after the last external one, and later ones PERIOD_TICKS apart.
- R8: `pfm_mode` goes high after the synchronized sync level has stayed low for the fallback interval. It is low again by the third clock after `sync_in` returns high.
- R9: While `rst` is high, `cycle_start`, `off_gated` and `pfm_mode` are all low, and the sync input's idle level is taken as high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous external sync pin, idle high |
| short_flag | input | 1 | Output short detected (feedback below threshold) |
| off_req | input | 1 | Turn-off request from the modulator |
| cycle_start | output | 1 | One-clock strobe starting a switching cycle |
| off_gated | output | 1 | Turn-off pulse after minimum on-time gating |
| pfm_mode | output | 1 | Sync held low: pulse-skipping operation selected |

## Verification
The bound checker watches four things on every cycle: that each strobe lasts one clock, that no turn-off pulse comes earlier than the minimum on-time after a strobe, that there is at most one turn-off pulse per strobe and none before the first one, and that the skip flag clears within three clocks of the pin going high. The bench scenarios cover what depends on spacing over many cycles. These are the internal period, the divide-by-three foldback in both timing sources, the latency from a pin edge to a strobe, the fallback interval after edges stop, and the exact cycle in which a held turn-off request is released.

// File: rtl/swfold_pkg.sv
package swfold_pkg;

    // Level the sync pin rests at when nothing drives cycles from outside.
    localparam logic SYNC_IDLE = 1'b1;

    // Foldback divide ratio applied when the output is shorted.
    localparam int FOLD_RATIO = 3;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    // State of the minimum on-time gate for the current cycle.
    typedef struct packed {
        logic armed;   // a strobe has started a cycle, turn-off not yet issued
        logic pend;    // a turn-off request is being held back
    } gate_st_t;

    // Quiet interval after which the external source is considered lost.
    function automatic int fallback_ticks(input int period);
        return period + period / 2;
    endfunction

endpackage

// File: rtl/swfold_sync_edge.sv
module swfold_sync_edge
    import swfold_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic lvl,
    output logic fall
);
    // sh[0..STAGES-1] are the synchronizer; sh[STAGES] is the previous level.
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= {(STAGES + 1){SYNC_IDLE}};
        end else begin
            sh <= {sh[STAGES-1:0], async_in};
        end
    end

    assign lvl  = sh[STAGES-1];
    assign fall = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/swfold_src_sel.sv
module swfold_src_sel
    import swfold_pkg::*;
#(
    parameter int PERIOD  = 16,
    parameter int TIMEOUT = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic fall,
    input  logic sync_lvl,
    output logic evt,
    output logic pfm_mode
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int WW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] phase;
    logic [WW-1:0] quiet;
    logic [WW-1:0] low_run;
    clk_src_e      src;
    logic          wrap;

    assign wrap = (phase == CW'(PERIOD - 1));
    assign evt  = fall | ((src == SRC_INT) & wrap);

    // Internal phase: restarts on every cycle event so both sources stay aligned.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (evt || wrap) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Source choice: an edge claims external timing, a long silence releases it.
    always_ff @(posedge clk) begin
        if (rst) begin
            src   <= SRC_INT;
            quiet <= '0;
        end else if (fall) begin
            src   <= SRC_EXT;
            quiet <= '0;
        end else if (quiet == WW'(TIMEOUT - 1)) begin
            src   <= SRC_INT;
        end else begin
            quiet <= quiet + 1'b1;
        end
    end

    // Pin held low selects pulse-skipping operation.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            pfm_mode <= 1'b0;
        end else if (sync_lvl) begin
            low_run  <= '0;
            pfm_mode <= 1'b0;
        end else if (low_run == WW'(TIMEOUT - 1)) begin
            pfm_mode <= 1'b1;
        end else begin
            low_run  <= low_run + 1'b1;
        end
    end

endmodule

// File: rtl/swfold_foldback.sv
module swfold_foldback
    import swfold_pkg::*;
#(
    parameter int RATIO = FOLD_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic short_flag,
    output logic cycle_start
);
    generate
        if (RATIO <= 1) begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) cycle_start <= 1'b0;
                else     cycle_start <= evt;
            end
        end else begin : g_div
            localparam int FW = $clog2(RATIO);
            logic [FW-1:0] slot;
            logic          emit;

            assign emit = evt & (~short_flag | (slot == '0));

            always_ff @(posedge clk) begin
                if (rst) begin
                    slot        <= '0;
                    cycle_start <= 1'b0;
                end else begin
                    cycle_start <= emit;
                    if (!short_flag) begin
                        slot <= '0;
                    end else if (evt) begin
                        slot <= (slot == FW'(RATIO - 1)) ? '0 : slot + 1'b1;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/swfold_min_on.sv
module swfold_min_on
    import swfold_pkg::*;
#(
    parameter int MIN_ON = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cycle_start,
    input  logic off_req,
    output logic off_gated
);
    localparam int BW = (MIN_ON > 2) ? $clog2(MIN_ON - 1) : 1;

    logic [BW-1:0] blank;
    gate_st_t      st;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank     <= '0;
            st        <= '0;
            off_gated <= 1'b0;
        end else if (cycle_start) begin
            blank     <= BW'(MIN_ON - 2);
            st.armed  <= 1'b1;
            st.pend   <= off_req;
            off_gated <= 1'b0;
        end else begin
            off_gated <= 1'b0;
            if (st.armed) begin
                if (blank != '0) begin
                    blank   <= blank - 1'b1;
                    st.pend <= st.pend | off_req;
                end else if (st.pend || off_req) begin
                    off_gated <= 1'b1;
                    st        <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/swfold_cycle_gen.sv
module swfold_cycle_gen
    import swfold_pkg::*;
#(
    parameter int PERIOD_TICKS = 16,
    parameter int MIN_ON_TICKS = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    input  logic short_flag,
    input  logic off_req,
    output logic cycle_start,
    output logic off_gated,
    output logic pfm_mode
);
    localparam int TIMEOUT_TICKS = fallback_ticks(PERIOD_TICKS);

    logic sync_lvl;
    logic sync_fall;
    logic evt;

    swfold_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .lvl      (sync_lvl),
        .fall     (sync_fall)
    );

    swfold_src_sel #(.PERIOD(PERIOD_TICKS), .TIMEOUT(TIMEOUT_TICKS)) u_src (
        .clk      (clk),
        .rst      (rst),
        .fall     (sync_fall),
        .sync_lvl (sync_lvl),
        .evt      (evt),
        .pfm_mode (pfm_mode)
    );

    swfold_foldback #(.RATIO(FOLD_RATIO)) u_fold (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .short_flag  (short_flag),
        .cycle_start (cycle_start)
    );

    swfold_min_on #(.MIN_ON(MIN_ON_TICKS)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .cycle_start (cycle_start),
        .off_req     (off_req),
        .off_gated   (off_gated)
    );

endmodule

// File: rtl/swfold_chk.sv
module swfold_chk #(
    parameter int MIN_ON = 4
) (
    input logic clk,
    input logic rst,
    input logic sync_in,
    input logic cycle_start,
    input logic off_gated,
    input logic pfm_mode
);
    localparam int SW = $clog2(MIN_ON + 1);

    logic [SW-1:0] since;
    logic [1:0]    offs;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            offs  <= '0;
            seen  <= 1'b0;
        end else begin
            if (cycle_start) begin
                since <= SW'(1);
                offs  <= '0;
                seen  <= 1'b1;
            end else begin
                if (since < SW'(MIN_ON)) since <= since + 1'b1;
                if (off_gated && offs != 2'd3) offs <= offs + 1'b1;
            end
        end
    end

    a_r1_strobe_single: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    a_r4_min_on_window: assert property (@(posedge clk) disable iff (rst)
        off_gated |-> (since >= SW'(MIN_ON)));

    a_r6_single_off: assert property (@(posedge clk) disable iff (rst)
        off_gated |-> (offs == 2'd0));

    a_r6_off_after_start: assert property (@(posedge clk) disable iff (rst)
        off_gated |-> seen);

    a_r8_pfm_clears: assert property (@(posedge clk) disable iff (rst)
        sync_in |-> ##3 !pfm_mode);

endmodule

bind swfold_cycle_gen swfold_chk #(.MIN_ON(MIN_ON_TICKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync_in     (sync_in),
    .cycle_start (cycle_start),
    .off_gated   (off_gated),
    .pfm_mode    (pfm_mode)
);

// File: tb/sim_swfold_cycle_gen.sv
`timescale 1ns/1ps
module sim_swfold_cycle_gen;
    localparam int P  = 16;
    localparam int MO = 4;
    localparam int TO = P + P / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b1;
    logic short_flag = 1'b0;
    logic off_req = 1'b0;
    logic cycle_start, off_gated, pfm_mode;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    swfold_cycle_gen #(.PERIOD_TICKS(P), .MIN_ON_TICKS(MO)) u0 (
        .clk(clk), .rst(rst), .sync_in(sync_in), .short_flag(short_flag),
        .off_req(off_req), .cycle_start(cycle_start), .off_gated(off_gated),
        .pfm_mode(pfm_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_start(output int c);
        int g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cycle_start && g < 400);
        if (!cycle_start) check("strobe-timeout", 0, 1);
        c = cyc;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R9 cycle_start in reset", int'(cycle_start), 0);
        check("R9 off_gated in reset", int'(off_gated), 0);
        check("R9 pfm_mode in reset", int'(pfm_mode), 0);
        rst = 1'b0;
    endtask

    task automatic t_internal();
        int a, b, c;
        wait_start(a);
        @(negedge clk);
        check("R1 strobe width", int'(cycle_start), 0);
        wait_start(b);
        wait_start(c);
        check("R1 internal period", b - a, P);
        check("R1 internal period again", c - b, P);
    endtask

    task automatic t_fold_internal();
        int a, b, c, d;
        wait_start(a);
        short_flag = 1'b1;
        wait_start(a);
        wait_start(b);
        wait_start(c);
        check("R3 folded period", b - a, 3 * P);
        check("R3 folded period again", c - b, 3 * P);
        short_flag = 1'b0;
        wait_start(c);
        wait_start(d);
        check("R3 period restored", d - c, P);
    endtask

    // Drives k falling edges with spacing sp, measuring n strobes after the first fall.
    task automatic run_ext(input int sp, input int k, input bit fold, input int n,
                           output int f0, output int ts[8]);
        int s;
        wait_start(s);
        short_flag = fold;
        f0 = cyc;
        fork
            begin
                for (int e = 0; e < k; e++) begin
                    sync_in = 1'b0;
                    repeat (sp / 2) @(negedge clk);
                    sync_in = 1'b1;
                    repeat (sp - sp / 2) @(negedge clk);
                end
            end
            begin
                for (int i = 0; i < n; i++) wait_start(ts[i]);
            end
        join
    endtask

    task automatic t_ext_fast();
        int f0;
        int ts[8];
        run_ext(10, 4, 1'b0, 6, f0, ts);
        check("R2 edge-to-strobe latency", ts[0] - f0, 3);
        check("R2 ext spacing 1", ts[1] - ts[0], 10);
        check("R2 ext spacing 2", ts[2] - ts[1], 10);
        check("R2 ext spacing 3", ts[3] - ts[2], 10);
        check("R7 first internal after timeout", ts[4] - ts[3], 2 * P);
        check("R7 internal resumes", ts[5] - ts[4], P);
    endtask

    task automatic t_ext_slow();
        int f0;
        int ts[8];
        run_ext(20, 4, 1'b0, 4, f0, ts);
        check("R2 slow edge latency", ts[0] - f0, 3);
        check("R2 slow spacing no internal strobe", ts[1] - ts[0], 20);
        check("R2 slow spacing again", ts[3] - ts[2], 20);
    endtask

    task automatic t_ext_fold();
        int f0;
        int ts[8];
        run_ext(10, 7, 1'b1, 3, f0, ts);
        check("R3 ext folded first strobe", ts[0] - f0, 3);
        check("R3 ext folded spacing", ts[1] - ts[0], 30);
        check("R3 ext folded spacing again", ts[2] - ts[1], 30);
        short_flag = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    task automatic t_min_on();
        int s, g, cnt;
        // early request held from the strobe cycle through the period
        wait_start(s);
        off_req = 1'b1;
        cnt = 0;
        g = -1;
        for (int i = 1; i < P; i++) begin
            @(negedge clk);
            if (off_gated) begin
                cnt++;
                if (g < 0) g = cyc;
            end
        end
        off_req = 1'b0;
        check("R4 early request released at window end", g - s, MO);
        check("R6 one turn-off per cycle", cnt, 1);
        // short pulse inside the window
        wait_start(s);
        @(negedge clk);
        off_req = 1'b1;
        @(negedge clk);
        off_req = 1'b0;
        g = -1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (off_gated && g < 0) g = cyc;
        end
        check("R4 held pulse released at window end", g - s, MO);
        // late request passes one clock later
        wait_start(s);
        repeat (7) @(negedge clk);
        off_req = 1'b1;
        @(negedge clk);
        check("R5 late request passes after one clock", int'(off_gated), 1);
        check("R5 late request timing", cyc - s, 8);
        off_req = 1'b0;
        @(negedge clk);
        check("R5 turn-off is one clock wide", int'(off_gated), 0);
        // no request: no turn-off
        wait_start(s);
        cnt = 0;
        for (int i = 1; i < P; i++) begin
            @(negedge clk);
            if (off_gated) cnt++;
        end
        check("R6 no request gives no turn-off", cnt, 0);
    endtask

    task automatic t_pfm();
        int s;
        wait_start(s);
        sync_in = 1'b0;
        repeat (10) @(negedge clk);
        check("R8 pfm not yet set", int'(pfm_mode), 0);
        repeat (TO + 6) @(negedge clk);
        check("R8 pfm set after low hold", int'(pfm_mode), 1);
        sync_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 pfm cleared after release", int'(pfm_mode), 0);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_fold_internal();
        t_ext_fast();
        t_ext_slow();
        t_ext_fold();
        t_min_on();
        t_pfm();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule